// File: doc/BRIEF.md
# Memory-Mapped Serial NOR Bridge

This bridge sits on the bus side of a serial NOR flash controller. A bus master issues single-byte reads and writes through a valid/ready handshake. The top bits of the address choose one of up to four flash banks, and the rest is the byte offset inside that bank's window. The bridge turns each cycle into serial flash traffic on shared clock, data and chip-select pins. Reads use either the plain read command or the fast form with a dummy byte. When a read follows the previous one at the next address, the chip select stays low and the bridge only clocks out one more data byte.

Writes are accepted only when three things hold: write-burst mode is on, software mode is off, and the bank's write-enable flag has been set beforehand by the command engine. Consecutive writes at incrementing addresses are merged into a single page-program transaction. That transaction stays open until 16 serial clock periods pass with no bus write, or until the next address would start a new flash page. When it closes, the bank's write-enable flag clears and a completion pulse is raised. A forbidden write and an access to a disabled bank each complete at once with an error pulse and no serial activity. The pins are shared with the command engine, so a new transaction waits for the grant input.

Back-pressure rules: the master must hold valid, write, address, data and strobe steady until it sees ready. Ready rises for exactly one cycle once the byte has been clocked in (read) or clocked out (write). Read data is valid in that same cycle.

Top module: `sflash_map_bridge`

## Requirements
- R1: After reset, all chip selects are high, the serial clock is low, ready is low, every write-enable flag is clear and no error or done pulse is raised.
- R2: Address bits [25:24] select the bank and bits [23:0] are the offset; only that bank's chip select (cs_n bit = bank) goes low. An access to a bank whose bank_en bit is 0 raises err_acc for one cycle, completes with rdata 0x00 and selects no bank.
- R3: A read opens with 0x03 and then offset bytes [23:16], [15:8], [7:0], followed by one data byte. Bytes go out most significant bit first. MOSI is launched while the serial clock is low and MISO is sampled on its rising edge. The byte received is returned on rdata.
- R4: With fast_mode set when a read transaction opens, the bridge sends 0x0B, the three offset bytes and one 0x00 dummy byte before the data byte.
- R5: A read to the same bank at the previous offset plus one continues the open transaction with one more data byte. Any other access closes it, and all chip selects then stay high for at least DSEL_SCK serial clock periods before the next select.
- R6: A write with strobe high is refused unless burst_mode=1, sw_mode=0 and that bank's write-enable flag is set. A refused write raises err_wr for one cycle, produces no serial activity and changes no flag.
- R7: An accepted write opens with 0x02 and the three offset bytes, then sends the data byte. Further writes at the next offset of the same bank append one data byte each to the same transaction.
- R8: A write transaction closes after GAP_SCK (16) serial clock periods with no bus write. On closing, the bank's write-enable flag clears and wr_done pulses for one cycle.
- R9: A sequential write whose offset has its low log2(PAGE_BYTES) bits all zero closes the open write transaction, with the R8 closing effects, instead of joining it.
- R10: The serial clock period is 2*ceil(ceil(CLK_HZ/SCK_MAX_HZ)/2) system clocks, so it never exceeds SCK_MAX_HZ. This is 2 clocks at 100 MHz.
- R11: Ready is a single-cycle pulse per transfer. While grant is low, no transaction opens and a waiting request is not acknowledged.
- R12: A one-cycle pulse on wen_set[b] sets the write-enable flag of bank b, shown on wen_flags[b].
- R13: A write with strobe low is acknowledged with no serial activity, no error pulse and no change to any flag or open transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request complete, one-cycle pulse |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 26 | Bank select [25:24] and byte offset [23:0] |
| bus_wdata | input | 8 | Write byte |
| bus_strb | input | 1 | Byte strobe for writes |
| bus_rdata | output | 8 | Read byte, valid with ready |
| bank_en | input | 4 | Bank present mask |
| fast_mode | input | 1 | Use fast-read form |
| burst_mode | input | 1 | Write-burst mode |
| sw_mode | input | 1 | Software mode (blocks writes) |
| wen_set | input | 4 | Per-bank write-enable set pulse |
| wen_flags | output | 4 | Per-bank write-enable flags |
| grant | input | 1 | Pins granted to the bridge |
| sck | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low chip selects |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| err_wr | output | 1 | Forbidden write pulse |
| err_acc | output | 1 | Forbidden access pulse |
| wr_done | output | 1 | Program transaction closed pulse |

## Verification
The hardest situation to reach is the write transaction that closes on its own. No bus event causes it. Only the silence after the last write, or a sequential write landing on a page start, ends it. The bench first writes a burst and checks that the select is still low part-way through the gap, then waits past 16 serial periods. For the page case it writes across offset 0x0FF/0x100, so that the closing write is itself refused, because closing the first transaction has already cleared the bank's write-enable flag.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_ACK,
    ST_DESEL
  } seq_state_t;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_PROG  = 8'h02;
endpackage

// File: rtl/sfb_shifter.sv
module sfb_shifter #(
  parameter int HALF = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] din,
  output logic       busy,
  output logic       done,
  output logic [7:0] dout,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic [2:0]    bits;
  logic [7:0]    sreg;

  assign mosi = sreg[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bits <= '0;
      sreg <= '0;
      dout <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      sck  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sreg <= din;
        busy <= 1'b1;
        cnt  <= '0;
        bits <= '0;
        sck  <= 1'b0;
      end else if (busy) begin
        if (cnt == CW'(HALF - 1)) begin
          cnt <= '0;
          if (!sck) begin
            sck  <= 1'b1;
            dout <= {dout[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bits == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bits <= bits + 3'd1;
              sreg <= {sreg[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // serial clock rests low between bytes
  p_sck_rest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // a completed byte always ends with the clock low
  p_done_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sck && !busy));
endmodule

// File: rtl/sfb_decode.sv
module sfb_decode #(
  parameter int NBANK  = 4,
  parameter int WIN_W  = 24,
  parameter int PAGE_W = 8
) (
  input  logic [WIN_W+$clog2(NBANK)-1:0] addr,
  input  logic [NBANK-1:0]               bank_en,
  output logic [$clog2(NBANK)-1:0]       bank,
  output logic [WIN_W-1:0]               off,
  output logic                           en,
  output logic                           page_start
);
  localparam int BANK_W = $clog2(NBANK);

  assign bank       = addr[WIN_W +: BANK_W];
  assign off        = addr[WIN_W-1:0];
  assign en         = bank_en[bank];
  assign page_start = (off[PAGE_W-1:0] == '0);
endmodule

// File: rtl/sfb_seq.sv
module sfb_seq
  import sfb_pkg::*;
#(
  parameter int NBANK    = 4,
  parameter int WIN_W    = 24,
  parameter int DSEL_CYC = 14,
  parameter int GAP_CYC  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic                     bus_strb,
  input  logic [7:0]               bus_wdata,
  output logic                     bus_ready,
  output logic [7:0]               bus_rdata,
  input  logic [$clog2(NBANK)-1:0] dec_bank,
  input  logic [WIN_W-1:0]         dec_off,
  input  logic                     dec_en,
  input  logic                     dec_page_start,
  input  logic                     fast_mode,
  input  logic                     burst_mode,
  input  logic                     sw_mode,
  input  logic [NBANK-1:0]         wen_set,
  output logic [NBANK-1:0]         wen_flags,
  input  logic                     grant,
  output logic [NBANK-1:0]         cs_n,
  output logic                     sh_start,
  output logic [7:0]               sh_din,
  input  logic                     sh_done,
  input  logic                     sh_busy,
  input  logic [7:0]               sh_rx,
  output logic                     err_wr,
  output logic                     err_acc,
  output logic                     wr_done
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int GW     = $clog2(GAP_CYC + 1);
  localparam int DW     = $clog2(DSEL_CYC + 1);

  seq_state_t        st;
  logic              sess_open, sess_wr;
  logic [BANK_W-1:0] sess_bank;
  logic [WIN_W-1:0]  cur_off, next_off;
  logic [7:0]        wdata_q, opcode_q, rdata_q, cmd_byte;
  logic [2:0]        idx, cmd_last;
  logic [NBANK-1:0]  cs_sel, wen_q, wen_clr;
  logic [GW-1:0]     gap_cnt;
  logic [DW-1:0]     dsel_cnt;
  logic              go;
  logic [23:0]       off24;

  logic nop_wr, wr_allowed, seq_hit, gap_exp, close_now;

  assign nop_wr     = bus_valid && bus_write && !bus_strb;
  assign wr_allowed = burst_mode && !sw_mode && wen_q[dec_bank];
  assign gap_exp    = sess_wr && (gap_cnt == GW'(GAP_CYC - 1));
  assign seq_hit    = sess_open && bus_valid && dec_en && (dec_bank == sess_bank)
                   && (dec_off == next_off) && (bus_write == sess_wr)
                   && (!sess_wr || (burst_mode && !sw_mode && !dec_page_start));
  assign close_now  = (st == ST_IDLE) && sess_open && !nop_wr
                   && ((bus_valid && !seq_hit) || (!bus_valid && gap_exp));
  assign wen_clr    = (close_now && sess_wr) ? (NBANK'(1) << sess_bank) : '0;

  assign off24 = 24'(cur_off);
  always_comb begin
    case (idx)
      3'd0:    cmd_byte = opcode_q;
      3'd1:    cmd_byte = off24[23:16];
      3'd2:    cmd_byte = off24[15:8];
      3'd3:    cmd_byte = off24[7:0];
      default: cmd_byte = 8'h00;
    endcase
  end

  assign sh_din    = (st == ST_DATA) ? (sess_wr ? wdata_q : 8'h00) : cmd_byte;
  assign sh_start  = go;
  assign bus_ready = (st == ST_ACK);
  assign bus_rdata = rdata_q;
  assign cs_n      = ~cs_sel;
  assign wen_flags = wen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sess_open <= 1'b0;
      sess_wr   <= 1'b0;
      sess_bank <= '0;
      cur_off   <= '0;
      next_off  <= '0;
      wdata_q   <= '0;
      opcode_q  <= '0;
      rdata_q   <= '0;
      idx       <= '0;
      cmd_last  <= '0;
      cs_sel    <= '0;
      wen_q     <= '0;
      gap_cnt   <= '0;
      dsel_cnt  <= '0;
      go        <= 1'b0;
      err_wr    <= 1'b0;
      err_acc   <= 1'b0;
      wr_done   <= 1'b0;
    end else begin
      go      <= 1'b0;
      err_wr  <= 1'b0;
      err_acc <= 1'b0;
      wr_done <= 1'b0;
      wen_q   <= (wen_q & ~wen_clr) | wen_set;
      case (st)
        ST_IDLE: begin
          if (sess_open && sess_wr) gap_cnt <= gap_cnt + GW'(1);
          if (nop_wr) begin
            st <= ST_ACK;
          end else if (close_now) begin
            st        <= ST_DESEL;
            cs_sel    <= '0;
            sess_open <= 1'b0;
            dsel_cnt  <= '0;
            wr_done   <= sess_wr;
          end else if (seq_hit) begin
            st      <= ST_DATA;
            go      <= 1'b1;
            cur_off <= dec_off;
            wdata_q <= bus_wdata;
          end else if (!sess_open && bus_valid) begin
            if (!dec_en) begin
              err_acc <= 1'b1;
              rdata_q <= 8'h00;
              st      <= ST_ACK;
            end else if (bus_write && !wr_allowed) begin
              err_wr <= 1'b1;
              st     <= ST_ACK;
            end else if (grant) begin
              sess_open <= 1'b1;
              sess_wr   <= bus_write;
              sess_bank <= dec_bank;
              cur_off   <= dec_off;
              wdata_q   <= bus_wdata;
              opcode_q  <= bus_write ? OP_PROG : (fast_mode ? OP_FREAD : OP_READ);
              cmd_last  <= (!bus_write && fast_mode) ? 3'd4 : 3'd3;
              cs_sel    <= NBANK'(1) << dec_bank;
              gap_cnt   <= '0;
              idx       <= '0;
              go        <= 1'b1;
              st        <= ST_CMD;
            end
          end
        end
        ST_CMD: begin
          if (sh_done) begin
            if (idx == cmd_last) st <= ST_DATA;
            else idx <= idx + 3'd1;
            go <= 1'b1;
          end
        end
        ST_DATA: begin
          if (sh_done) begin
            if (!sess_wr) rdata_q <= sh_rx;
            next_off <= cur_off + WIN_W'(1);
            gap_cnt  <= '0;
            st       <= ST_ACK;
          end
        end
        ST_ACK: st <= ST_IDLE;
        ST_DESEL: begin
          if (dsel_cnt == DW'(DSEL_CYC - 1)) st <= ST_IDLE;
          else dsel_cnt <= dsel_cnt + DW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // at most one bank selected at a time
  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // the byte engine is never restarted mid-byte
  p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> !sh_busy);
  // refused transfers never touch the pins
  p_forbid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_wr || err_acc) |-> (&cs_n));
  // one acknowledge per transfer
  p_ready_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);
  // a select only starts while granted
  p_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&cs_n) |-> $past(grant));
  // closing a program transaction drops the bank's write enable
  p_wen_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (close_now && sess_wr && !wen_set[sess_bank]) |=> !wen_flags[$past(sess_bank)]);
endmodule

// File: rtl/sflash_map_bridge.sv
module sflash_map_bridge #(
  parameter int NBANK      = 4,
  parameter int WIN_W      = 24,
  parameter int PAGE_BYTES = 256,
  parameter int CLK_HZ     = 200_000_000,
  parameter int SCK_MAX_HZ = 50_000_000,
  parameter int DSEL_SCK   = 7,
  parameter int GAP_SCK    = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_valid,
  output logic                             bus_ready,
  input  logic                             bus_write,
  input  logic [WIN_W+$clog2(NBANK)-1:0]   bus_addr,
  input  logic [7:0]                       bus_wdata,
  input  logic                             bus_strb,
  output logic [7:0]                       bus_rdata,
  input  logic [NBANK-1:0]                 bank_en,
  input  logic                             fast_mode,
  input  logic                             burst_mode,
  input  logic                             sw_mode,
  input  logic [NBANK-1:0]                 wen_set,
  output logic [NBANK-1:0]                 wen_flags,
  input  logic                             grant,
  output logic                             sck,
  output logic [NBANK-1:0]                 cs_n,
  output logic                             mosi,
  input  logic                             miso,
  output logic                             err_wr,
  output logic                             err_acc,
  output logic                             wr_done
);
  localparam int BANK_W   = $clog2(NBANK);
  localparam int PAGE_W   = $clog2(PAGE_BYTES);
  localparam int DIV      = (CLK_HZ + SCK_MAX_HZ - 1) / SCK_MAX_HZ;
  localparam int HALF     = (DIV + 1) / 2 < 1 ? 1 : (DIV + 1) / 2;
  localparam int SCK_PER  = 2 * HALF;
  localparam int DSEL_CYC = DSEL_SCK * SCK_PER;
  localparam int GAP_CYC  = GAP_SCK * SCK_PER;

  logic [BANK_W-1:0] dec_bank;
  logic [WIN_W-1:0]  dec_off;
  logic              dec_en, dec_page_start;
  logic              sh_start, sh_done, sh_busy;
  logic [7:0]        sh_din, sh_rx;

  sfb_decode #(.NBANK(NBANK), .WIN_W(WIN_W), .PAGE_W(PAGE_W)) u_decode (
    .addr       (bus_addr),
    .bank_en    (bank_en),
    .bank       (dec_bank),
    .off        (dec_off),
    .en         (dec_en),
    .page_start (dec_page_start)
  );

  sfb_seq #(.NBANK(NBANK), .WIN_W(WIN_W), .DSEL_CYC(DSEL_CYC), .GAP_CYC(GAP_CYC)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_valid      (bus_valid),
    .bus_write      (bus_write),
    .bus_strb       (bus_strb),
    .bus_wdata      (bus_wdata),
    .bus_ready      (bus_ready),
    .bus_rdata      (bus_rdata),
    .dec_bank       (dec_bank),
    .dec_off        (dec_off),
    .dec_en         (dec_en),
    .dec_page_start (dec_page_start),
    .fast_mode      (fast_mode),
    .burst_mode     (burst_mode),
    .sw_mode        (sw_mode),
    .wen_set        (wen_set),
    .wen_flags      (wen_flags),
    .grant          (grant),
    .cs_n           (cs_n),
    .sh_start       (sh_start),
    .sh_din         (sh_din),
    .sh_done        (sh_done),
    .sh_busy        (sh_busy),
    .sh_rx          (sh_rx),
    .err_wr         (err_wr),
    .err_acc        (err_acc),
    .wr_done        (wr_done)
  );

  sfb_shifter #(.HALF(HALF)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sh_start),
    .din   (sh_din),
    .busy  (sh_busy),
    .done  (sh_done),
    .dout  (sh_rx),
    .sck   (sck),
    .mosi  (mosi),
    .miso  (miso)
  );
endmodule

// File: tb/test_sflash_map_bridge.sv
`timescale 1ns/1ps
module test_sflash_map_bridge;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_valid = 0, bus_write = 0, bus_strb = 0;
  logic [25:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_ready;
  logic [7:0]  bus_rdata;
  logic [3:0]  bank_en = 4'b0111;
  logic        fast_mode = 0, burst_mode = 0, sw_mode = 0, grant = 1;
  logic [3:0]  wen_set = '0, wen_flags, cs_n;
  logic        sck, mosi, miso = 1'b0;
  logic        err_wr, err_acc, wr_done;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  sflash_map_bridge #(.CLK_HZ(100_000_000)) i_sflash_map_bridge (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_strb(bus_strb), .bus_rdata(bus_rdata), .bank_en(bank_en),
    .fast_mode(fast_mode), .burst_mode(burst_mode), .sw_mode(sw_mode),
    .wen_set(wen_set), .wen_flags(wen_flags), .grant(grant), .sck(sck),
    .cs_n(cs_n), .mosi(mosi), .miso(miso), .err_wr(err_wr),
    .err_acc(err_acc), .wr_done(wr_done)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0] fb [0:63];
  logic [7:0] lb [0:63];
  logic [7:0] fsh = '0;
  int fn = 0, fbits = 0, ln = 0, txn = 0;
  wire cs_idle = &cs_n;

  task automatic upd_miso();
    int bi, hdr;
    logic [7:0] d;
    bi  = fbits / 8;
    hdr = (fn > 0 && fb[0] == 8'h0B) ? 5 : 4;
    if (fn >= 4 && bi >= hdr) begin
      d    = mem_byte({fb[1], fb[2], fb[3]} + 24'(bi - hdr));
      miso = d[7 - (fbits % 8)];
    end else begin
      miso = 1'b0;
    end
  endtask

  always @(posedge sck) begin
    if (!cs_idle) begin
      fsh = {fsh[6:0], mosi};
      fbits++;
      if (fbits % 8 == 0 && fn < 64) begin
        fb[fn] = fsh;
        fn++;
      end
      upd_miso();
    end
  end

  always @(posedge cs_idle) begin
    if (fn > 0) begin
      for (int i = 0; i < 64; i++) lb[i] = fb[i];
      ln = fn;
      txn++;
    end
    fn = 0;
    fbits = 0;
    upd_miso();
  end

  // ---------------- pulse / timing monitors ----------------
  int n_ewr = 0, n_eacc = 0, n_done = 0, n_rd = 0;
  int run = 0, last_run = 0;
  time prev_rise = 0, min_dt = 1000;
  always @(negedge clk) begin
    if (err_wr)  n_ewr++;
    if (err_acc) n_eacc++;
    if (wr_done) n_done++;
    if (cs_idle) run++;
    else begin
      if (run > 0) last_run = run;
      run = 0;
    end
  end
  always @(posedge sck) begin
    if (prev_rise != 0 && ($time - prev_rise) < min_dt) min_dt = $time - prev_rise;
    prev_rise = $time;
  end

  // ---------------- scoreboard ----------------
  logic [7:0] exp_q[$];
  always @(negedge clk) begin
    if (rst_n && bus_valid && bus_ready && !bus_write) begin
      n_rd++;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3 unexpected read actual=%0h expected=none", bus_rdata);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL R3/R2 read data actual=%0h expected=%0h", bus_rdata, e);
        end
      end
    end
  end

  task automatic bus_op(input logic wr, input logic [1:0] bank, input logic [23:0] off,
                        input logic [7:0] d, input logic strb, input logic [7:0] exp);
    @(negedge clk);
    bus_write = wr; bus_addr = {bank, off}; bus_wdata = d; bus_strb = strb;
    if (!wr) exp_q.push_back(exp);
    bus_valid = 1'b1;
    do @(negedge clk); while (!bus_ready);
    @(posedge clk);
    #1 bus_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] bank, input logic [23:0] off);
    bus_op(1'b0, bank, off, 8'h00, 1'b1, mem_byte(off));
  endtask

  task automatic check_txn(input string req, input int len, input logic [7:0] e [0:7]);
    int bad;
    bad = (ln != len);
    for (int i = 0; i < len && i < 8; i++) if (lb[i] !== e[i]) bad = 1;
    n_chk++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s txn len=%0d b0=%0h b3=%0h expected len=%0d b0=%0h b3=%0h",
               req, ln, lb[0], lb[3], len, e[0], e[3]);
    end
  endtask

  task automatic pulse_wen(input logic [3:0] m);
    @(negedge clk); wen_set = m;
    @(negedge clk); wen_set = '0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    logic [7:0] e [0:7];
    int t0, d0, r0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 cs_n", cs_n, 4'hF);
    check("R1 sck", sck, 0);
    check("R1 ready", bus_ready, 0);
    check("R1 wen_flags", wen_flags, 0);
    check("R1 flags", {err_wr, err_acc, wr_done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 / R5: read with sequential continuation
    rd(2'd0, 24'h000010);
    rd(2'd0, 24'h000011);
    rd(2'd0, 24'h000012);
    t0 = txn;
    check("R5 session still open", cs_n, 4'b1110);
    rd(2'd2, 24'h001234);
    check("R5 closed on non-sequential", txn, t0 + 1);
    e = '{8'h03, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00};
    check_txn("R3 read command and address", 7, e);
    check("R2 bank 2 selected", cs_n, 4'b1011);
    check("R5 deselect time", (last_run >= 14 && last_run < 40) ? 1 : 0, 1);
    check("R10 sck period ns", min_dt, 20);

    // R4: fast read
    fast_mode = 1'b1;
    rd(2'd2, 24'h001300);
    fast_mode = 1'b0;
    rd(2'd0, 24'h000050);
    e = '{8'h0B, 8'h00, 8'h13, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    check_txn("R4 fast read with dummy", 6, e);

    // R2: disabled bank
    bus_op(1'b0, 2'd3, 24'h000000, 8'h00, 1'b1, 8'h00);
    check("R2 err_acc pulse", n_eacc, 1);
    repeat (4) @(negedge clk);
    check("R2 no select on disabled bank", cs_n, 4'hF);

    // R6 / R12: write permission
    t0 = txn;
    burst_mode = 1'b1;
    bus_op(1'b1, 2'd1, 24'h000020, 8'h5A, 1'b1, 8'h00);
    pulse_wen(4'b0010);
    check("R12 wen flag set", wen_flags, 4'b0010);
    burst_mode = 1'b0;
    bus_op(1'b1, 2'd1, 24'h000020, 8'h5A, 1'b1, 8'h00);
    burst_mode = 1'b1; sw_mode = 1'b1;
    bus_op(1'b1, 2'd1, 24'h000020, 8'h5A, 1'b1, 8'h00);
    sw_mode = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 refused writes", n_ewr, 3);
    check("R6 no serial activity", txn, t0);
    check("R6 wen unchanged", wen_flags, 4'b0010);

    // R13: strobe-less write
    bus_op(1'b1, 2'd1, 24'h000040, 8'hEE, 1'b0, 8'h00);
    repeat (4) @(negedge clk);
    check("R13 no pins", cs_n, 4'hF);
    check("R13 no flags", n_ewr + n_done, 3);
    check("R13 wen kept", wen_flags, 4'b0010);

    // R7 / R8: merged burst and gap close
    d0 = n_done;
    bus_op(1'b1, 2'd1, 24'h000040, 8'hAA, 1'b1, 8'h00);
    bus_op(1'b1, 2'd1, 24'h000041, 8'hBB, 1'b1, 8'h00);
    bus_op(1'b1, 2'd1, 24'h000042, 8'hCC, 1'b1, 8'h00);
    repeat (24) @(negedge clk);
    check("R8 burst still open inside gap", cs_n, 4'b1101);
    repeat (60) @(negedge clk);
    check("R8 burst closed", txn, t0 + 1);
    e = '{8'h02, 8'h00, 8'h00, 8'h40, 8'hAA, 8'hBB, 8'hCC, 8'h00};
    check_txn("R7 program burst bytes", 7, e);
    check("R8 wr_done pulse", n_done, d0 + 1);
    check("R8 wen cleared", wen_flags, 4'b0000);

    // R9: page boundary
    pulse_wen(4'b0010);
    r0 = n_ewr;
    bus_op(1'b1, 2'd1, 24'h0000FE, 8'h11, 1'b1, 8'h00);
    bus_op(1'b1, 2'd1, 24'h0000FF, 8'h22, 1'b1, 8'h00);
    bus_op(1'b1, 2'd1, 24'h000100, 8'h33, 1'b1, 8'h00);
    repeat (4) @(negedge clk);
    e = '{8'h02, 8'h00, 8'h00, 8'hFE, 8'h11, 8'h22, 8'h00, 8'h00};
    check_txn("R9 page close", 6, e);
    check("R9 wr_done on page close", n_done, d0 + 2);
    check("R9 write after close refused", n_ewr, r0 + 1);

    // R11: grant
    grant = 1'b0;
    r0 = n_rd;
    fork
      rd(2'd0, 24'h000080);
      begin
        repeat (20) @(negedge clk);
        check("R11 no select without grant", cs_n, 4'hF);
        check("R11 no ack without grant", n_rd, r0);
        grant = 1'b1;
      end
    join
    check("R11 read after grant", n_rd, r0 + 1);
    check("R3 scoreboard drained", exp_q.size(), 0);
    report();
  end
endmodule